// File: doc/BRIEF.md
# Row-Latched Byte Store Write Controller

This block fronts a small byte-wide non-volatile data store of 128 bytes, arranged as four rows of 32 bytes. Reads from the store window behave like ordinary memory. Writes do not reach the store directly. Software first arms a set of 32 byte latches with a mode bit in a two-bit control register, then writes the bytes it wants into those latches. A separate start bit then launches a timed programming cycle, which copies every latched byte into one row of the array in a single step.

The row that receives the data is the row addressed by the most recent latch write. Only bytes that were actually written during the load phase are committed. The other bytes of that row keep their old contents. Accesses made in the wrong mode are dropped without any effect. A second write to a latch that already holds data stores the bitwise AND of the old and new values.

A wait-mode handshake lets a power manager park the block. The request is granted at once when the block is idle, and is held off until the end of a cycle that is already running. The array is a plain register file, and the cycle length is a parameter.

Top module: `ee_row_writer`

The controller is a three-state machine:

- **ST_READ**: the latches are disarmed.
- **ST_LOAD**: the latches are armed.
- **ST_PROG**: a cycle is running.

The machine moves between these states through four transitions:

- **T_ARM** goes from ST_READ to ST_LOAD when the latch bit is written as 1.
- **T_DISARM** goes from ST_LOAD to ST_READ when the latch bit is written as 0 and the start bit as 0. It discards the latches.
- **T_START** goes from ST_LOAD to ST_PROG when the start bit is written as 1.
- **T_FINISH** goes from ST_PROG to ST_READ when the cycle timer expires. It commits the latches and clears them.

## Requirements
- R1: After reset the control register reads 00h, `busy` is 0, and `wait_ack` is high for as long as `wait_req` is high.
- R2: A control read returns bits 7:2 as 0, bit 1 as the latch-enable bit and bit 0 as the program-start bit, and it drives `rdata_oe` high.
- R3: With latch-enable at 0, a store read returns the addressed array byte with `rdata_oe` high. A store write in this mode leaves the array unchanged.
- R4: With latch-enable at 1, a store read keeps `rdata_oe` low.
- R5: With latch-enable at 1 and no cycle running, a store write captures its data in the latch chosen by `addr[4:0]`. The target row of the next cycle is `addr[6:5]` of the most recent such write.
- R6: A cycle writes only the bytes that were latched into the target row. All other bytes of the array keep their values.
- R7: A second write to a latch that already holds data, before the latches are cleared, stores the AND of the old and new data.
- R8: Writing the start bit as 1 starts a cycle only when latch-enable is already 1. The cycle holds `busy` high for PROG_CYCLES clocks, and at its end start and latch-enable both clear in the same clock.
- R9: While a cycle runs, control writes are ignored, including any attempt to clear latch-enable. Store writes are ignored as well.
- R10: Clearing latch-enable while no cycle runs discards every latched byte, so a later cycle commits nothing.
- R11: `wait_ack` follows `wait_req` when no cycle runs. While `busy` is high it stays low, and it rises only after the cycle ends.
- R12: A reset during a cycle aborts it. The control register returns to 00h, the target row is unchanged, and the latch flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sel | input | 1 | Access targets the store window |
| ctl_sel | input | 1 | Access targets the control register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Store byte address (row in 6:5, column in 4:0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data is driven |
| busy | output | 1 | Programming cycle in progress (mirrors start bit) |
| wait_req | input | 1 | Wait-mode request |
| wait_ack | output | 1 | Wait-mode grant |

## Verification
Two things can land on the same clock edge. The first is the cycle-end commit, which clears both control bits at once, together with a wait request that is waiting on that cycle. The second is an attempt by software to clear latch-enable during the cycle, which has to be refused. The bench raises `wait_req` and writes 00h to the control register while `busy` is high. It then checks three things: the control read still shows both bits set, `wait_ack` stays low until the clock in which `busy` falls, and the commit still lands. Bytes stored into the latches while the cycle runs must not appear in the array afterwards.

// File: rtl/ee_row_pkg.sv
package ee_row_pkg;

    typedef enum logic [1:0] {
        ST_READ = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ee_state_e;

    localparam int CTL_LAT_BIT = 1;
    localparam int CTL_PGM_BIT = 0;
    localparam int BYTE_W      = 8;

endpackage

// File: rtl/ee_row_ctrl.sv
module ee_row_ctrl
    import ee_row_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wd_lat,
    input  logic wd_pgm,
    input  logic wait_req,
    output logic lat,
    output logic pgm,
    output logic commit,
    output logic discard,
    output logic wait_ack
);

    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    ee_state_e         state_q;
    ee_state_e         state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic              timer_done;

    assign timer_done = (cnt_q == CNT_W'(PROG_CYCLES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
        end else begin
            state_q <= state_n;
        end
    end

    // Next-state logic: T_ARM, T_DISARM, T_START, T_FINISH
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_READ: begin
                if (ctl_wr && wd_lat) begin
                    state_n = ST_LOAD;          // T_ARM
                end
            end
            ST_LOAD: begin
                if (ctl_wr) begin
                    if (wd_pgm) begin
                        state_n = ST_PROG;      // T_START
                    end else if (!wd_lat) begin
                        state_n = ST_READ;      // T_DISARM
                    end
                end
            end
            ST_PROG: begin
                if (timer_done) begin
                    state_n = ST_READ;          // T_FINISH
                end
            end
            default: state_n = ST_READ;
        endcase
    end

    // Output logic
    always_comb begin
        lat      = 1'b0;
        pgm      = 1'b0;
        commit   = 1'b0;
        discard  = 1'b0;
        wait_ack = 1'b0;
        unique case (state_q)
            ST_READ: begin
                wait_ack = wait_req;
            end
            ST_LOAD: begin
                lat      = 1'b1;
                wait_ack = wait_req;
                discard  = ctl_wr && !wd_pgm && !wd_lat;
            end
            ST_PROG: begin
                lat    = 1'b1;
                pgm    = 1'b1;
                commit = timer_done;
            end
            default: begin
                lat = 1'b0;
            end
        endcase
    end

    // Cycle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_PROG) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ee_latch_bank.sv
module ee_latch_bank
    import ee_row_pkg::*;
#(
    parameter int ROW_BYTES = 32,
    parameter int ROWS      = 4,
    localparam int COL_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [COL_W-1:0]                   col,
    input  logic [ROW_W-1:0]                   row_in,
    input  logic [BYTE_W-1:0]                  wdata,
    input  logic                               clear,
    output logic [ROW_BYTES-1:0][BYTE_W-1:0]   data,
    output logic [ROW_BYTES-1:0]               flags,
    output logic [ROW_W-1:0]                   row_q
);

    for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data[i]  <= '0;
                flags[i] <= 1'b0;
            end else if (clear) begin
                data[i]  <= '0;
                flags[i] <= 1'b0;
            end else if (wr && (col == COL_W'(i))) begin
                data[i]  <= flags[i] ? (data[i] & wdata) : wdata;
                flags[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (wr) begin
            row_q <= row_in;
        end
    end

endmodule

// File: rtl/ee_row_array.sv
module ee_row_array
    import ee_row_pkg::*;
#(
    parameter int ROW_BYTES = 32,
    parameter int ROWS      = 4,
    localparam int COL_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DEPTH    = ROWS * ROW_BYTES,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              commit,
    input  logic [ROW_W-1:0]                  row,
    input  logic [ROW_BYTES-1:0][BYTE_W-1:0]  latch_data,
    input  logic [ROW_BYTES-1:0]              flags,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [BYTE_W-1:0]                 rd_data
);

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < ROW_BYTES; c++) begin : g_col
            always_ff @(posedge clk) begin
                if (commit && (row == ROW_W'(r)) && flags[c]) begin
                    cells[r*ROW_BYTES + c] <= latch_data[c];
                end
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/ee_row_writer.sv
module ee_row_writer
    import ee_row_pkg::*;
#(
    parameter int ROW_BYTES   = 32,
    parameter int ROWS        = 4,
    parameter int PROG_CYCLES = 16,
    localparam int COL_W      = $clog2(ROW_BYTES),
    localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ADDR_W     = $clog2(ROWS * ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_sel,
    input  logic              ctl_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              busy,
    input  logic              wait_req,
    output logic              wait_ack
);

    logic                              lat;
    logic                              pgm;
    logic                              commit;
    logic                              discard;
    logic                              ctl_wr;
    logic                              mem_wr;
    logic                              mem_rd_ok;
    logic [ROW_BYTES-1:0][BYTE_W-1:0]  latch_data;
    logic [ROW_BYTES-1:0]              latch_flags;
    logic [ROW_W-1:0]                  tgt_row;
    logic [BYTE_W-1:0]                 arr_data;
    logic [BYTE_W-1:0]                 ctl_view;

    assign ctl_wr    = wr_en && ctl_sel;
    assign mem_wr    = wr_en && mem_sel && !ctl_sel && lat && !pgm;
    assign mem_rd_ok = rd_en && mem_sel && !ctl_sel && !lat;

    ee_row_ctrl #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wd_lat   (wdata[CTL_LAT_BIT]),
        .wd_pgm   (wdata[CTL_PGM_BIT]),
        .wait_req (wait_req),
        .lat      (lat),
        .pgm      (pgm),
        .commit   (commit),
        .discard  (discard),
        .wait_ack (wait_ack)
    );

    ee_latch_bank #(
        .ROW_BYTES (ROW_BYTES),
        .ROWS      (ROWS)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mem_wr),
        .col    (addr[COL_W-1:0]),
        .row_in (addr[ADDR_W-1:COL_W]),
        .wdata  (wdata),
        .clear  (commit || discard),
        .data   (latch_data),
        .flags  (latch_flags),
        .row_q  (tgt_row)
    );

    ee_row_array #(
        .ROW_BYTES (ROW_BYTES),
        .ROWS      (ROWS)
    ) u_array (
        .clk        (clk),
        .commit     (commit),
        .row        (tgt_row),
        .latch_data (latch_data),
        .flags      (latch_flags),
        .rd_addr    (addr),
        .rd_data    (arr_data)
    );

    always_comb begin
        ctl_view              = '0;
        ctl_view[CTL_LAT_BIT] = lat;
        ctl_view[CTL_PGM_BIT] = pgm;
    end

    always_comb begin
        rdata    = '0;
        rdata_oe = 1'b0;
        if (rd_en && ctl_sel) begin
            rdata    = ctl_view;
            rdata_oe = 1'b1;
        end else if (mem_rd_ok) begin
            rdata    = arr_data;
            rdata_oe = 1'b1;
        end
    end

    assign busy = pgm;

endmodule

// File: rtl/ee_row_writer_chk.sv
module ee_row_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_sel,
    input logic       ctl_sel,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic       busy,
    input logic       lat,
    input logic       wait_req,
    input logic       wait_ack
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl_sel) |-> (rdata_oe && rdata[7:2] == 6'd0 && rdata[1] == lat));

    assert_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mem_sel && !ctl_sel && lat) |-> !rdata_oe);

    assert_busy_needs_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lat);

    assert_start_from_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(lat));

    assert_joint_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(lat));

    assert_lat_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lat) && $past(busy)) |-> !busy);

    assert_wait_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !busy) |-> wait_ack);

    assert_wait_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wait_ack);

endmodule

bind ee_row_writer ee_row_writer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_sel  (mem_sel),
    .ctl_sel  (ctl_sel),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .busy     (busy),
    .lat      (lat),
    .wait_req (wait_req),
    .wait_ack (wait_ack)
);

// File: tb/ee_row_writer_bench.sv
`timescale 1ns/1ps
module ee_row_writer_bench;

    localparam int PC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_sel = 1'b0;
    logic       ctl_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       busy;
    logic       wait_req = 1'b0;
    logic       wait_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [128];

    always #2.5 clk = ~clk;

    ee_row_writer #(.ROW_BYTES(32), .ROWS(4), .PROG_CYCLES(PC)) u_ee_row_writer (
        .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .ctl_sel(ctl_sel),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy),
        .wait_req(wait_req), .wait_ack(wait_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_sel = 1'b1; wr_en = 1'b1; wdata = v;
        @(posedge clk); #1;
        ctl_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic mem_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        mem_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic ctl_read(output logic [7:0] d, output logic oe);
        @(negedge clk);
        ctl_sel = 1'b1; rd_en = 1'b1;
        #1; d = rdata; oe = rdata_oe;
        ctl_sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic mem_read(input logic [6:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        mem_sel = 1'b1; rd_en = 1'b1; addr = a;
        #1; d = rdata; oe = rdata_oe;
        mem_sel = 1'b0; rd_en = 1'b0;
    endtask

    // starts a cycle and counts the clocks busy stays high
    task automatic start_and_wait(output int n);
        n = 0;
        ctl_write(8'h03);
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic check_byte(input logic [6:0] a, input string req);
        logic [7:0] d; logic oe;
        mem_read(a, d, oe);
        check(oe && d == exp_mem[a], req, d, exp_mem[a]);
    endtask

    task automatic t_reset;
        logic [7:0] d; logic oe;
        ctl_read(d, oe);
        check(oe && d == 8'h00, "R1 ctl after reset", d, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        wait_req = 1'b1; #1;
        check(wait_ack == 1'b1, "R1 wait ack after reset", wait_ack, 1);
        wait_req = 1'b0;
    endtask

    task automatic t_fill;
        int n; logic [7:0] d; logic oe;
        for (int r = 0; r < 4; r++) begin
            ctl_write(8'h02);
            ctl_read(d, oe);
            check(d == 8'h02, "R2 ctl reads latch bit", d, 2);
            for (int i = 0; i < 32; i++) begin
                mem_write(7'(r*32 + i), 8'(r*40 + i*3 + 1));
                exp_mem[r*32 + i] = 8'(r*40 + i*3 + 1);
            end
            start_and_wait(n);
            check(n == PC, "R8 cycle length", n, PC);
            ctl_read(d, oe);
            check(d == 8'h00, "R8 both bits clear", d, 0);
        end
        for (int a = 0; a < 128; a += 9) check_byte(7'(a), "R3 R5 readback");
        check_byte(7'd127, "R5 last byte");
    endtask

    task automatic t_partial;
        int n;
        ctl_write(8'h02);
        mem_write(7'(32 + 3), 8'h5A);
        mem_write(7'(64 + 7), 8'h33);
        start_and_wait(n);
        exp_mem[64 + 3] = 8'h5A;
        exp_mem[64 + 7] = 8'h33;
        check_byte(7'(64 + 3), "R5 row from last write");
        check_byte(7'(64 + 7), "R5 latched byte");
        check_byte(7'(32 + 3), "R6 other row untouched");
        check_byte(7'(64 + 4), "R6 unflagged byte kept");
        check_byte(7'(64 + 31), "R6 unflagged byte kept");
    endtask

    task automatic t_and;
        int n;
        ctl_write(8'h02);
        mem_write(7'(96 + 4), 8'hF0);
        mem_write(7'(96 + 4), 8'h3C);
        start_and_wait(n);
        exp_mem[96 + 4] = 8'h30;
        check_byte(7'(96 + 4), "R7 AND of repeated writes");
    endtask

    task automatic t_read_while_latched;
        int n; logic [7:0] d; logic oe;
        ctl_write(8'h02);
        mem_read(7'd10, d, oe);
        check(oe == 1'b0, "R4 store read not driven", oe, 0);
        ctl_read(d, oe);
        check(oe && d == 8'h02, "R2 ctl layout in load", d, 2);
        ctl_write(8'h00);
    endtask

    task automatic t_write_read_mode;
        mem_write(7'd5, 8'h00);
        check_byte(7'd5, "R3 write in read mode ignored");
    endtask

    task automatic t_discard;
        int n;
        ctl_write(8'h02);
        mem_write(7'd6, 8'h00);
        ctl_write(8'h00);
        ctl_write(8'h02);
        start_and_wait(n);
        check_byte(7'd6, "R10 discarded latch not committed");
    endtask

    task automatic t_pgm_needs_lat;
        logic [7:0] d; logic oe;
        ctl_write(8'h01);
        ctl_read(d, oe);
        check(d == 8'h00, "R8 start without latch ignored", d, 0);
        check(busy == 1'b0, "R8 no busy without latch", busy, 0);
    endtask

    task automatic t_busy_ignores_and_wait;
        logic [7:0] d; logic oe; int waits;
        ctl_write(8'h02);
        mem_write(7'd40, 8'h11);
        ctl_write(8'h03);
        wait_req = 1'b1;
        ctl_write(8'h00);
        ctl_read(d, oe);
        check(d == 8'h03, "R9 latch clear refused while busy", d, 3);
        check(wait_ack == 1'b0, "R11 wait held while busy", wait_ack, 0);
        mem_write(7'd41, 8'h00);
        waits = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (!busy) break;
            if (wait_ack) waits++;
        end
        check(waits == 0, "R11 no ack during cycle", waits, 0);
        check(wait_ack == 1'b1, "R11 ack after cycle", wait_ack, 1);
        wait_req = 1'b0;
        exp_mem[40] = 8'h11;
        check_byte(7'd40, "R9 commit lands");
        check_byte(7'd41, "R9 store write during cycle ignored");
        ctl_read(d, oe);
        check(d == 8'h00, "R9 ctl clear after cycle", d, 0);
    endtask

    task automatic t_reset_mid;
        logic [7:0] d; logic oe; int n;
        ctl_write(8'h02);
        mem_write(7'd0, 8'h00);
        ctl_write(8'h03);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ctl_read(d, oe);
        check(d == 8'h00, "R12 ctl after abort", d, 0);
        check(busy == 1'b0, "R12 busy after abort", busy, 0);
        check_byte(7'd0, "R12 row unchanged");
        ctl_write(8'h02);
        start_and_wait(n);
        check_byte(7'd0, "R12 flags cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_partial();
        t_and();
        t_read_while_latched();
        t_write_read_mode();
        t_discard();
        t_pgm_needs_lat();
        t_busy_ignores_and_wait();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule